// File: doc/BRIEF.md
# I2C Master Stop-Condition Controller

This block is the bus-condition section of an I2C master. Software asks for a start or a stop with single-cycle trigger strobes. The block checks each stop request against the master's current situation and accepts it only inside the wait window where ending the transfer is legal. For an accepted stop it drives the open-drain SCL and SDA pull-down enables through a timed sequence. SDA goes low first. SCL is then released, and the block waits for SCL to read high. After a hold time, SDA is released while SCL is high, which forms the stop condition on the bus.

The pending-stop flag clears itself on any of five events: arbitration loss, a release command, disabling the controller, a stop condition seen on the bus, or reset. Any rejected start or stop request raises a one-cycle error pulse. A separate detector sees a rising SDA edge while SCL is high and pulses a stop-detect output. Byte shifting, address matching and slave behaviour belong to other blocks. The byte phase arrives as inputs: `in_wait` says the shift logic is holding the bus in a wait, and `wait_sel8` says that wait follows the eighth clock (1) or the ninth clock (0).

Top module: `i2c_stop_ctl`

## Requirements
- R1: A stop request made while `master_mode` is 0 or `en` is 0 is rejected: `stop_pend` stays 0 and `req_err` pulses.
- R2: A stop request made in the same cycle as a start request is rejected. The start is rejected too, so `start_go` stays 0 and `req_err` pulses.
- R3: A stop request made while no wait period is active (`in_wait` = 0, a byte on the move) is rejected.
- R4: A stop request made while `stop_pend` is already 1 has no effect on the flag or on the running sequence, and it raises `req_err`.
- R5: A stop accepted in a wait after the ninth clock first holds SCL and SDA low together (`scl_oe` = `sda_oe` = 1) for exactly HOLD_CYC cycles (default 4). It then releases SCL and keeps SDA low for as long as SCL reads low. After SCL reads high it keeps SDA low for at least HOLD_CYC more cycles, then releases SDA while still leaving SCL released.
- R6: A receive-side stop accepted in a wait after the eighth clock (`wait_sel8` = 1) starts with SDA driven low and SCL released in the very next cycle. The stop therefore forms during the high phase of the ninth clock.
- R7: While transmitting (`xmit` = 1), a stop is accepted only when `wait_sel8` = 0. A request during a wait after the eighth clock is rejected.
- R8: While receiving (`xmit` = 0), a stop is accepted only if `ack_en` = 0 and `last_rx` = 1. Otherwise it is rejected.
- R9: `stop_pend` returns to 0, and both enables return to 0, one cycle after any of these: `arb_lost`, `release_cmd`, `en` = 0, or `stop_det`. After reset all outputs read 0.
- R10: `stop_pend` reads 0 during the cycle in which a stop request is written. It reads 1 from the next cycle if the request is accepted.
- R11: `req_err` is a single-cycle pulse, raised in the cycle after a rejected request.
- R12: `stop_det` is high for exactly one cycle for each rising SDA edge sampled while SCL is high.
- R13: A lone start request made while `en` = 1 and no stop is pending gives a one-cycle `start_go` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Controller enable; 0 stops operation and clears the pending stop |
| master_mode | input | 1 | 1 while this node owns the bus as master |
| xmit | input | 1 | 1 = master transmitting, 0 = master receiving |
| ack_en | input | 1 | 1 = acknowledge generation enabled for received bytes |
| last_rx | input | 1 | 1 = the slave has been told the last byte was received |
| in_wait | input | 1 | 1 = the shift logic is holding a wait period |
| wait_sel8 | input | 1 | 1 = wait follows the eighth clock, 0 = follows the ninth |
| start_req | input | 1 | Start trigger write strobe |
| stop_req | input | 1 | Stop trigger write strobe |
| arb_lost | input | 1 | Arbitration-lost strobe |
| release_cmd | input | 1 | Communication-release command strobe |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_oe | output | 1 | 1 = pull SDA low |
| stop_pend | output | 1 | Stop trigger flag |
| start_go | output | 1 | One-cycle pulse: start request accepted |
| req_err | output | 1 | One-cycle pulse: a start or stop request was rejected |
| stop_det | output | 1 | One-cycle pulse: stop condition seen on the bus |

## Verification
The bench works through each rejection window: transfer in progress, slave mode, a collision with a start, a transmit request in the eighth-clock wait, and a receive request with acknowledge still enabled or before the last byte. A gate that was too permissive would set the flag and start driving SDA low in the middle of a byte. It holds SCL low from outside to stretch the clock. A sequencer that counted time in place of watching the line would then release SDA while SCL was low, which produces no stop at all. A second request while one is pending, and each of the abort events, are applied mid-sequence. A design that re-armed the sequencer or ignored an abort would leave SDA stuck low.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE    = 3'd0,
      SQ_SDA_LO  = 3'd1,
      SQ_SCL_REL = 3'd2,
      SQ_HOLD    = 3'd3,
      SQ_SDA_REL = 3'd4
   } sq_state_t;

   // Legal stop window for the current direction and wait position.
   function automatic logic stop_window(input logic xmit,
                                        input logic wait_sel8,
                                        input logic ack_en,
                                        input logic last_rx);
      if (xmit) return !wait_sel8;
      return !ack_en && last_rx;
   endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_hi,
   output logic stop_det
);

   initial begin
      assert (SYNC_DEPTH >= 0 && SYNC_DEPTH <= 4)
         else $error("SYNC_DEPTH must lie in 0..4");
   end

   logic scl_s, sda_s;
   logic scl_p, sda_p;

   generate
      if (SYNC_DEPTH == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_DEPTH-1:0] scl_r, sda_r;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               scl_r <= '1;
               sda_r <= '1;
            end else begin
               scl_r[0] <= scl_in;
               sda_r[0] <= sda_in;
               for (int i = 1; i < SYNC_DEPTH; i++) begin
                  scl_r[i] <= scl_r[i-1];
                  sda_r[i] <= sda_r[i-1];
               end
            end
         end
         assign scl_s = scl_r[SYNC_DEPTH-1];
         assign sda_s = sda_r[SYNC_DEPTH-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_hi   = scl_s;
   assign stop_det = scl_s & scl_p & sda_s & ~sda_p;

   // R12: the stop detect never lasts two cycles
   a_r12_det_single: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !stop_det);

endmodule

// File: rtl/i2c_stop_gate.sv
module i2c_stop_gate
   import i2c_stop_pkg::*;
(
   input  logic en,
   input  logic master_mode,
   input  logic xmit,
   input  logic ack_en,
   input  logic last_rx,
   input  logic in_wait,
   input  logic wait_sel8,
   input  logic start_req,
   input  logic stop_req,
   input  logic stop_pend,
   input  logic blocked,
   output logic stop_ok,
   output logic stop_rej,
   output logic start_ok,
   output logic start_rej,
   output logic defer9
);

   logic stop_legal;

   always_comb begin
      stop_legal = en && master_mode && !start_req && !stop_pend && in_wait
                   && !blocked && stop_window(xmit, wait_sel8, ack_en, last_rx);
      stop_ok    = stop_req && stop_legal;
      stop_rej   = stop_req && !stop_legal;
      start_ok   = start_req && !stop_req && en && !stop_pend && !blocked;
      start_rej  = start_req && !start_ok;
      defer9     = !xmit && wait_sel8;
   end

endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
   import i2c_stop_pkg::*;
#(
   parameter int HOLD_CYC = 4,
   localparam int CW = $clog2(HOLD_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic defer9,
   input  logic abort,
   input  logic scl_hi,
   output logic scl_oe,
   output logic sda_oe
);

   localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD_CYC - 1);

   sq_state_t      state;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         cnt   <= '0;
      end else if (abort) begin
         state <= SQ_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: if (go) begin
               if (defer9) state <= SQ_SCL_REL;
               else begin
                  state <= SQ_SDA_LO;
                  cnt   <= CNT_LOAD;
               end
            end
            SQ_SDA_LO: begin
               if (cnt == '0) state <= SQ_SCL_REL;
               else           cnt   <= cnt - 1'b1;
            end
            SQ_SCL_REL: if (scl_hi) begin
               state <= SQ_HOLD;
               cnt   <= CNT_LOAD;
            end
            SQ_HOLD: begin
               if (cnt == '0) state <= SQ_SDA_REL;
               else           cnt   <= cnt - 1'b1;
            end
            SQ_SDA_REL: state <= SQ_SDA_REL;
            default:    state <= SQ_IDLE;
         endcase
      end
   end

   assign scl_oe = (state == SQ_SDA_LO);
   assign sda_oe = (state == SQ_SDA_LO) || (state == SQ_SCL_REL) || (state == SQ_HOLD);

   // R5: SDA is let go only while SCL is released
   a_r5_sda_after_scl: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> !scl_oe);
   // R5: SCL is released with SDA still held low unless aborted
   a_r5_scl_before_sda: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_oe) && !$past(abort)) |-> sda_oe);

endmodule

// File: rtl/i2c_stop_ctl.sv
module i2c_stop_ctl #(
   parameter int HOLD_CYC   = 4,
   parameter int SYNC_DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic master_mode,
   input  logic xmit,
   input  logic ack_en,
   input  logic last_rx,
   input  logic in_wait,
   input  logic wait_sel8,
   input  logic start_req,
   input  logic stop_req,
   input  logic arb_lost,
   input  logic release_cmd,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_oe,
   output logic sda_oe,
   output logic stop_pend,
   output logic start_go,
   output logic req_err,
   output logic stop_det
);

   initial begin
      assert (HOLD_CYC >= 1) else $error("HOLD_CYC must be at least 1");
   end

   logic scl_hi;
   logic stop_ok, stop_rej, start_ok, start_rej, defer9;
   logic blocked, clr;

   assign blocked = arb_lost | release_cmd | stop_det;
   assign clr     = blocked | ~en;

   i2c_line_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_samp (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .scl_hi   (scl_hi),
      .stop_det (stop_det)
   );

   i2c_stop_gate u_gate (
      .en          (en),
      .master_mode (master_mode),
      .xmit        (xmit),
      .ack_en      (ack_en),
      .last_rx     (last_rx),
      .in_wait     (in_wait),
      .wait_sel8   (wait_sel8),
      .start_req   (start_req),
      .stop_req    (stop_req),
      .stop_pend   (stop_pend),
      .blocked     (blocked),
      .stop_ok     (stop_ok),
      .stop_rej    (stop_rej),
      .start_ok    (start_ok),
      .start_rej   (start_rej),
      .defer9      (defer9)
   );

   i2c_stop_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (stop_ok),
      .defer9 (defer9),
      .abort  (clr),
      .scl_hi (scl_hi),
      .scl_oe (scl_oe),
      .sda_oe (sda_oe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_pend <= 1'b0;
         start_go  <= 1'b0;
         req_err   <= 1'b0;
      end else begin
         if (clr)          stop_pend <= 1'b0;
         else if (stop_ok) stop_pend <= 1'b1;
         start_go <= start_ok;
         req_err  <= stop_rej | start_rej;
      end
   end

   a_r1_not_master: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !master_mode && !stop_pend) |=> (!stop_pend && req_err));
   a_r2_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && start_req && !stop_pend) |=> (!stop_pend && !start_go && req_err));
   a_r3_busy_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !in_wait && !stop_pend) |=> !stop_pend);
   a_r4_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && stop_pend) |=> req_err);
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost || release_cmd || !en) |=> (!stop_pend && !sda_oe && !scl_oe));
   a_r10_flag_late: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_pend) |-> $past(stop_req));
   a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> $past(stop_req || start_req));

endmodule

// File: tb/i2c_stop_ctl_tb_top.sv
module i2c_stop_ctl_tb_top;

   localparam int HOLD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, master_mode = 1'b0, xmit = 1'b0, ack_en = 1'b0, last_rx = 1'b0;
   logic in_wait = 1'b0, wait_sel8 = 1'b0, start_req = 1'b0, stop_req = 1'b0;
   logic arb_lost = 1'b0, release_cmd = 1'b0, ext_scl_low = 1'b0;
   logic scl_in, sda_in, scl_oe, sda_oe, stop_pend, start_go, req_err, stop_det;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   // open-drain bus with pull-ups; the bench may stretch SCL
   assign scl_in = ~scl_oe & ~ext_scl_low;
   assign sda_in = ~sda_oe;

   i2c_stop_ctl #(.HOLD_CYC(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .master_mode(master_mode), .xmit(xmit),
      .ack_en(ack_en), .last_rx(last_rx), .in_wait(in_wait), .wait_sel8(wait_sel8),
      .start_req(start_req), .stop_req(stop_req), .arb_lost(arb_lost),
      .release_cmd(release_cmd), .scl_in(scl_in), .sda_in(sda_in),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .stop_pend(stop_pend), .start_go(start_go),
      .req_err(req_err), .stop_det(stop_det)
   );

   task automatic chk(input bit ok, input string rid, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rid, act, exp);
      end
   endtask

   // scoreboard of expected request verdicts
   typedef struct {
      bit    acc;
      bit    pend;
      string rid;
   } verdict_t;
   verdict_t sbq[$];
   event ev_chk;

   initial begin
      forever begin
         @(ev_chk);
         while (sbq.size() > 0) begin
            verdict_t v;
            v = sbq.pop_front();
            chk(req_err == !v.acc, {v.rid, " err"}, int'(req_err), int'(!v.acc));
            chk(stop_pend == v.pend, {v.rid, " pend"}, int'(stop_pend), int'(v.pend));
         end
      end
   end

   task automatic drive_stop(input bit acc, input bit pend, input string rid);
      verdict_t v;
      v.acc = acc; v.pend = pend; v.rid = rid;
      stop_req = 1'b1;
      sbq.push_back(v);
      @(negedge clk);
      stop_req = 1'b0;
      -> ev_chk;
      #1;
   endtask

   task automatic setup(input bit tx, input bit w8, input bit ack, input bit last);
      en = 1'b1; master_mode = 1'b1; in_wait = 1'b1;
      xmit = tx; wait_sel8 = w8; ack_en = ack; last_rx = last;
   endtask

   task automatic pulse(ref logic s);
      s = 1'b1;
      @(negedge clk);
      s = 1'b0;
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired (run hung)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int n;
      bit held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(!scl_oe && !sda_oe && !stop_pend && !req_err && !start_go, "R9 reset state",
          {scl_oe, sda_oe, stop_pend, req_err}, 0);

      // R3: transfer running
      setup(1, 0, 0, 0); in_wait = 1'b0;
      drive_stop(0, 0, "R3 stop during byte");
      // R11: error is a single pulse
      @(negedge clk);
      chk(req_err == 1'b0, "R11 err width", req_err, 0);
      // R7: transmit, wait after eighth clock
      setup(1, 1, 0, 0);
      drive_stop(0, 0, "R7 tx in eighth wait");
      // R1: not master
      setup(1, 0, 0, 0); master_mode = 1'b0;
      drive_stop(0, 0, "R1 slave mode");
      // R1: disabled
      setup(1, 0, 0, 0); en = 1'b0;
      drive_stop(0, 0, "R1 disabled");
      // R8: receive with ack on, then before last byte
      setup(0, 0, 1, 1);
      drive_stop(0, 0, "R8 ack enabled");
      setup(0, 0, 0, 0);
      drive_stop(0, 0, "R8 not last byte");
      // R2: collision with start
      setup(1, 0, 0, 0);
      start_req = 1'b1;
      drive_stop(0, 0, "R2 with start");
      start_req = 1'b0;
      chk(start_go == 1'b0, "R2 start_go", start_go, 0);
      // R13: lone start
      @(negedge clk);
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      chk(start_go == 1'b1, "R13 start_go", start_go, 1);
      @(negedge clk);
      chk(start_go == 1'b0, "R13 start_go width", start_go, 0);

      // R5 / R10: full sequence with SCL stretched by the bench
      ext_scl_low = 1'b1;
      setup(1, 0, 0, 0);
      stop_req = 1'b1;
      #1;
      chk(stop_pend == 1'b0, "R10 flag during write", stop_pend, 0);
      stop_req = 1'b0;
      drive_stop(1, 1, "R10 accept tx");
      n = 0;
      while (scl_oe && sda_oe && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(n == HOLD, "R5 both-low length", n, HOLD);
      chk(!scl_oe && sda_oe, "R5 scl released sda low", {scl_oe, sda_oe}, 1);
      held = 1'b1;
      repeat (8) begin
         @(negedge clk);
         if (!sda_oe || scl_oe) held = 1'b0;
      end
      chk(held, "R5 sda held while scl stretched", held, 1);
      ext_scl_low = 1'b0;
      n = 0;
      while (sda_oe && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(n >= HOLD, "R5 hold after scl high", n, HOLD);
      chk(!scl_oe, "R5 scl released at sda release", scl_oe, 0);
      n = 0;
      while (!stop_det && n < 20) begin
         n++;
         @(negedge clk);
      end
      chk(stop_det == 1'b1, "R12 stop detected", stop_det, 1);
      @(negedge clk);
      chk(stop_det == 1'b0, "R12 detect width", stop_det, 0);
      chk(stop_pend == 1'b0, "R9 cleared by bus stop", stop_pend, 0);

      // R4 repeat, then R9 arbitration loss
      ext_scl_low = 1'b1;
      drive_stop(1, 1, "R4 first accept");
      drive_stop(0, 1, "R4 repeat ignored");
      chk(scl_oe && sda_oe, "R4 sequence undisturbed", {scl_oe, sda_oe}, 3);
      pulse(arb_lost);
      chk(!stop_pend && !scl_oe && !sda_oe, "R9 arb lost", {stop_pend, scl_oe, sda_oe}, 0);
      // R9 release command
      drive_stop(1, 1, "R9 accept before release");
      pulse(release_cmd);
      chk(!stop_pend && !sda_oe, "R9 release cmd", {stop_pend, sda_oe}, 0);
      // R9 disable
      drive_stop(1, 1, "R9 accept before disable");
      en = 1'b0;
      @(negedge clk);
      chk(!stop_pend && !sda_oe, "R9 disabled", {stop_pend, sda_oe}, 0);
      en = 1'b1;

      // R8 legal receive stop after ninth clock, normal sequence start
      setup(0, 0, 0, 1);
      drive_stop(1, 1, "R8 receive accept");
      chk(scl_oe && sda_oe, "R8 normal start", {scl_oe, sda_oe}, 3);
      pulse(release_cmd);

      // R6 receive stop in eighth-clock wait: ninth clock high phase
      ext_scl_low = 1'b0;
      setup(0, 1, 0, 1);
      drive_stop(1, 1, "R6 accept eighth wait");
      chk(!scl_oe && sda_oe, "R6 scl free sda low", {scl_oe, sda_oe}, 1);
      n = 0;
      while (stop_pend && n < 50) begin
         n++;
         @(negedge clk);
      end
      chk(!stop_pend && !sda_oe, "R6 stop completed", {stop_pend, sda_oe}, 0);

      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule